// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits beside one processor and decides which interrupt, if any, is presented to it. It keeps four values: the processor's current priority, a request priority for inter-processor interrupts (IPIs), the identifier of the one pending interrupt and that interrupt's priority. A numerically lower priority is more favoured. It also keeps a sticky flag that records that an offer was turned away. The external source controller offers interrupts one at a time. Each offer is either taken, which may displace the previous pending source back to the source side as a reject, or refused, which sets the sticky flag.

Software reaches the block through a strobe port with a 2-bit opcode and a 32-bit write word. There are four operations: accept, which reads the pending interrupt and acknowledges it; set processor priority; set IPI priority; and end-of-interrupt. Every result is a registered pulse or value that appears one clock after the edge that processed the request. The interrupt line is registered in the same way. At most one action is taken per clock. A register operation wins over an offer in the same cycle, and the source side sees no result for the offer that lost and must hold it.

Top module: `intr_present_ctrl`

## Requirements
- R1: After synchronous reset the processor priority is 0x00, the IPI priority 0xFF, the pending priority 0xFF, the pending id 0 and the sticky flag clear. The interrupt line is low, and an accept returns 0x00000000.
- R2: An offer (id, prio) is taken only if prio is strictly lower than the processor priority, the IPI priority and the pending priority. When it is taken, `dlv_ok` pulses and the id and prio become pending.
- R3: A pending id displaced by any operation is reported on `rej_valid`/`rej_id`, unless it is 0 or the IPI id 2. Those two values are never reported.
- R4: A refused offer pulses `dlv_fail` and sets the sticky flag. The flag stays set until a resend report clears it.
- R5: `irq_out` is high exactly when the pending id is nonzero and the pending priority is numerically lower than the processor priority. It reflects the state one clock after the edge that changed it.
- R6: Accept (opcode 0) returns `{processor priority[7:0], pending id[23:0]}` on `rd_data` with `rd_valid`. If the id was nonzero, the processor priority takes the pending priority, the pending priority returns to 0xFF and the id clears.
- R7: Set-IPI (opcode 2) stores m = wdata[7:0]. If m is below the processor priority and m is at most the pending priority, the pending id is displaced (see R3), the pending priority becomes m and the pending id becomes 2.
- R8: When set-IPI raises the IPI priority numerically, the sticky flag is reported on `resend_req` and cleared.
- R9: Set-priority (opcode 1) with p = wdata[7:0] above the current value stores p. If the IPI priority is below p and at most the pending priority, the IPI becomes pending and displaces any other id (see R3). The sticky flag is then reported on `resend_req` and cleared.
- R10: Set-priority with p below the current value stores p. If p is at most the pending priority, the pending id is displaced and cleared and the pending priority becomes 0xFF. If p equals the current value, nothing changes and nothing is reported.
- R11: End-of-interrupt (opcode 3) applies the R9 behaviour with wdata[31:24] as the new priority, whatever its relation to the old one. It then forwards wdata[23:0] on `eoi_valid`/`eoi_id` unless that id is 2.
- R12: A register strobe and an offer in the same cycle process only the register operation. Neither `dlv_ok` nor `dlv_fail` pulses for that offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register operation strobe |
| reg_op | input | 2 | 0 accept, 1 set priority, 2 set IPI priority, 3 end-of-interrupt |
| reg_wdata | input | 32 | Write word of the operation |
| off_valid | input | 1 | Delivery offer present |
| off_id | input | 24 | Offered source id |
| off_prio | input | 8 | Offered priority |
| rd_valid | output | 1 | Accept result valid |
| rd_data | output | 32 | Accept result word |
| dlv_ok | output | 1 | Offer taken |
| dlv_fail | output | 1 | Offer refused |
| rej_valid | output | 1 | Displaced id to redeliver |
| rej_id | output | 24 | Displaced id |
| resend_req | output | 1 | Sticky flag reported and cleared |
| eoi_valid | output | 1 | End-of-interrupt forwarded to source side |
| eoi_id | output | 24 | Forwarded id |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
If the stored state goes wrong, the block shows it at the ports only once a later action reads that state. A wrong pending id or priority shows up on `irq_out` on the next clock. It also shows up in the word returned by the next accept, or in the `dlv_ok`/`dlv_fail` answer to the next offer. A lost or stuck sticky flag is hidden until the next priority-lowering or IPI-raising operation, when `resend_req` differs. The bench therefore drives long mixed sequences of offers and register operations over a small range of priorities, so that each stored value is read back within a few cycles of being written.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    OP_ACCEPT  = 2'd0,
    OP_SETPRIO = 2'd1,
    OP_SETIPI  = 2'd2,
    OP_EOI     = 2'd3
  } ipc_op_e;
endpackage

// File: rtl/ipc_select.sv
module ipc_select
  import ipc_pkg::*;
(
  input  logic       reg_valid,
  input  logic [1:0] reg_op,
  input  logic       off_valid,
  output logic       do_reg,
  output logic       do_offer,
  output ipc_op_e    op
);
  // one action per clock; software strobe has precedence
  always_comb begin
    do_reg   = reg_valid;
    do_offer = off_valid && !reg_valid;
    op       = ipc_op_e'(reg_op);
  end
endmodule

// File: rtl/ipc_next.sv
module ipc_next
  import ipc_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int ID_W   = 24,
  parameter int IPI_ID = 2,
  localparam int DATA_W = PRIO_W + ID_W
) (
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] mfrr,
  input  logic [PRIO_W-1:0] ppri,
  input  logic [ID_W-1:0]   xisr,
  input  logic              need,
  input  logic              do_reg,
  input  ipc_op_e           op,
  input  logic [DATA_W-1:0] wdata,
  input  logic              do_offer,
  input  logic [ID_W-1:0]   off_id,
  input  logic [PRIO_W-1:0] off_prio,
  output logic [PRIO_W-1:0] n_cppr,
  output logic [PRIO_W-1:0] n_mfrr,
  output logic [PRIO_W-1:0] n_ppri,
  output logic [ID_W-1:0]   n_xisr,
  output logic              n_need,
  output logic              ev_rd,
  output logic [DATA_W-1:0] ev_rd_data,
  output logic              ev_rej,
  output logic [ID_W-1:0]   ev_rej_id,
  output logic              ev_resend,
  output logic              ev_eoi,
  output logic [ID_W-1:0]   ev_eoi_id,
  output logic              ev_ok,
  output logic              ev_fail
);
  localparam logic [ID_W-1:0]   IPI_CODE = ID_W'(IPI_ID);
  localparam logic [PRIO_W-1:0] LEAST    = '1;

  logic [PRIO_W-1:0] wprio;
  logic [PRIO_W-1:0] eprio;
  logic [ID_W-1:0]   eid;
  logic [ID_W-1:0]   displaced;
  logic              lower_en;
  logic [PRIO_W-1:0] lower_val;

  assign wprio = wdata[PRIO_W-1:0];
  assign eprio = wdata[DATA_W-1 -: PRIO_W];
  assign eid   = wdata[ID_W-1:0];

  always_comb begin
    n_cppr     = cppr;
    n_mfrr     = mfrr;
    n_ppri     = ppri;
    n_xisr     = xisr;
    n_need     = need;
    ev_rd      = 1'b0;
    ev_rd_data = '0;
    ev_resend  = 1'b0;
    ev_eoi     = 1'b0;
    ev_eoi_id  = '0;
    ev_ok      = 1'b0;
    ev_fail    = 1'b0;
    displaced  = '0;
    lower_en   = 1'b0;
    lower_val  = '0;

    if (do_reg) begin
      case (op)
        OP_ACCEPT: begin
          ev_rd      = 1'b1;
          ev_rd_data = {cppr, xisr};
          if (xisr != '0) begin
            n_cppr = ppri;
            n_ppri = LEAST;
            n_xisr = '0;
          end
        end
        OP_SETPRIO: begin
          if (wprio > cppr) begin
            lower_en  = 1'b1;
            lower_val = wprio;
          end else if (wprio < cppr) begin
            n_cppr = wprio;
            if (wprio <= ppri) begin
              displaced = xisr;
              n_xisr    = '0;
              n_ppri    = LEAST;
            end
          end
        end
        OP_SETIPI: begin
          n_mfrr = wprio;
          if (wprio < cppr && wprio <= ppri) begin
            displaced = xisr;
            n_ppri    = wprio;
            n_xisr    = IPI_CODE;
          end
          if (wprio > mfrr) begin
            ev_resend = need;
            n_need    = 1'b0;
          end
        end
        OP_EOI: begin
          lower_en  = 1'b1;
          lower_val = eprio;
          if (eid != IPI_CODE) begin
            ev_eoi    = 1'b1;
            ev_eoi_id = eid;
          end
        end
        default: ;
      endcase
    end else if (do_offer) begin
      if (off_prio < cppr && off_prio < mfrr && off_prio < ppri) begin
        ev_ok     = 1'b1;
        displaced = xisr;
        n_xisr    = off_id;
        n_ppri    = off_prio;
      end else begin
        ev_fail = 1'b1;
        n_need  = 1'b1;
      end
    end

    // shared priority-lowering path (set-priority upward and EOI)
    if (lower_en) begin
      n_cppr = lower_val;
      if (mfrr < lower_val && mfrr <= ppri) begin
        displaced = xisr;
        n_ppri    = mfrr;
        n_xisr    = IPI_CODE;
      end
      ev_resend = need;
      n_need    = 1'b0;
    end

    ev_rej    = (displaced != '0) && (displaced != IPI_CODE);
    ev_rej_id = ev_rej ? displaced : '0;
  end
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl
  import ipc_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int ID_W   = 24,
  parameter int IPI_ID = 2,
  localparam int DATA_W = PRIO_W + ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic [1:0]        reg_op,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              off_valid,
  input  logic [ID_W-1:0]   off_id,
  input  logic [PRIO_W-1:0] off_prio,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dlv_ok,
  output logic              dlv_fail,
  output logic              rej_valid,
  output logic [ID_W-1:0]   rej_id,
  output logic              resend_req,
  output logic              eoi_valid,
  output logic [ID_W-1:0]   eoi_id,
  output logic              irq_out
);
  localparam logic [ID_W-1:0] IPI_CODE = ID_W'(IPI_ID);

  logic [PRIO_W-1:0] cppr_q, mfrr_q, ppri_q;
  logic [ID_W-1:0]   xisr_q;
  logic              need_q;

  logic              do_reg, do_offer;
  ipc_op_e           op;

  logic [PRIO_W-1:0] n_cppr, n_mfrr, n_ppri;
  logic [ID_W-1:0]   n_xisr;
  logic              n_need;
  logic              ev_rd, ev_rej, ev_resend, ev_eoi, ev_ok, ev_fail;
  logic [DATA_W-1:0] ev_rd_data;
  logic [ID_W-1:0]   ev_rej_id, ev_eoi_id;

  ipc_select u_sel (
    .reg_valid (reg_valid),
    .reg_op    (reg_op),
    .off_valid (off_valid),
    .do_reg    (do_reg),
    .do_offer  (do_offer),
    .op        (op)
  );

  ipc_next #(.PRIO_W(PRIO_W), .ID_W(ID_W), .IPI_ID(IPI_ID)) u_next (
    .cppr       (cppr_q),
    .mfrr       (mfrr_q),
    .ppri       (ppri_q),
    .xisr       (xisr_q),
    .need       (need_q),
    .do_reg     (do_reg),
    .op         (op),
    .wdata      (reg_wdata),
    .do_offer   (do_offer),
    .off_id     (off_id),
    .off_prio   (off_prio),
    .n_cppr     (n_cppr),
    .n_mfrr     (n_mfrr),
    .n_ppri     (n_ppri),
    .n_xisr     (n_xisr),
    .n_need     (n_need),
    .ev_rd      (ev_rd),
    .ev_rd_data (ev_rd_data),
    .ev_rej     (ev_rej),
    .ev_rej_id  (ev_rej_id),
    .ev_resend  (ev_resend),
    .ev_eoi     (ev_eoi),
    .ev_eoi_id  (ev_eoi_id),
    .ev_ok      (ev_ok),
    .ev_fail    (ev_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr_q     <= '0;
      mfrr_q     <= '1;
      ppri_q     <= '1;
      xisr_q     <= '0;
      need_q     <= 1'b0;
      irq_out    <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      dlv_ok     <= 1'b0;
      dlv_fail   <= 1'b0;
      rej_valid  <= 1'b0;
      rej_id     <= '0;
      resend_req <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_id     <= '0;
    end else begin
      cppr_q     <= n_cppr;
      mfrr_q     <= n_mfrr;
      ppri_q     <= n_ppri;
      xisr_q     <= n_xisr;
      need_q     <= n_need;
      irq_out    <= (n_xisr != '0) && (n_ppri < n_cppr);
      rd_valid   <= ev_rd;
      rd_data    <= ev_rd_data;
      dlv_ok     <= ev_ok;
      dlv_fail   <= ev_fail;
      rej_valid  <= ev_rej;
      rej_id     <= ev_rej_id;
      resend_req <= ev_resend;
      eoi_valid  <= ev_eoi;
      eoi_id     <= ev_eoi_id;
    end
  end

  p_reject_filter_r3: assert property (@(posedge clk) disable iff (rst)
    rej_valid |-> (rej_id != '0 && rej_id != IPI_CODE));

  p_ok_fail_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(dlv_ok && dlv_fail));

  p_fail_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
    dlv_fail |-> need_q);

  p_irq_level_r5: assert property (@(posedge clk) disable iff (rst)
    irq_out == (xisr_q != '0 && ppri_q < cppr_q));

  p_accept_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_op == 2'd0 && xisr_q != '0) |=> (xisr_q == '0 && ppri_q == '1));

  p_resend_single_r8: assert property (@(posedge clk) disable iff (rst)
    resend_req |=> !resend_req);

  p_reg_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && off_valid) |=> !(dlv_ok || dlv_fail));
endmodule

// File: tb/sim_intr_present_ctrl.sv
`timescale 1ns/1ps
module sim_intr_present_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_valid = 1'b0;
  logic [1:0]  reg_op = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        off_valid = 1'b0;
  logic [23:0] off_id = 24'd0;
  logic [7:0]  off_prio = 8'd0;
  logic        rd_valid, dlv_ok, dlv_fail, rej_valid, resend_req, eoi_valid, irq_out;
  logic [31:0] rd_data;
  logic [23:0] rej_id, eoi_id;

  int n_chk = 0;
  int n_bad = 0;
  bit armed = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  intr_present_ctrl u0 (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_op(reg_op),
    .reg_wdata(reg_wdata), .off_valid(off_valid), .off_id(off_id),
    .off_prio(off_prio), .rd_valid(rd_valid), .rd_data(rd_data),
    .dlv_ok(dlv_ok), .dlv_fail(dlv_fail), .rej_valid(rej_valid),
    .rej_id(rej_id), .resend_req(resend_req), .eoi_valid(eoi_valid),
    .eoi_id(eoi_id), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cppr, m_mfrr, m_ppri, m_xisr, m_need;
  bit e_rd, e_ok, e_fail, e_rej, e_rs, e_eoi, e_irq;
  logic [31:0] e_rdd;
  int e_rejid, e_eoiid;

  always @(posedge clk) begin
    if (rst) begin
      m_cppr = 0; m_mfrr = 255; m_ppri = 255; m_xisr = 0; m_need = 0;
      e_rd = 0; e_ok = 0; e_fail = 0; e_rej = 0; e_rs = 0; e_eoi = 0; e_irq = 0;
      e_rdd = 0; e_rejid = 0; e_eoiid = 0;
      armed = 1;
    end else begin
      int gone, p, lowr;
      e_rd = 0; e_ok = 0; e_fail = 0; e_rs = 0; e_eoi = 0;
      e_rdd = 0; e_eoiid = 0; gone = 0; lowr = -1;
      if (reg_valid) begin
        p = int'(reg_wdata[7:0]);
        if (reg_op == 2'd0) begin
          e_rd = 1; e_rdd = {m_cppr[7:0], m_xisr[23:0]};
          if (m_xisr != 0) begin m_cppr = m_ppri; m_ppri = 255; m_xisr = 0; end
        end else if (reg_op == 2'd1) begin
          if (p > m_cppr) lowr = p;
          else if (p < m_cppr) begin
            m_cppr = p;
            if (p <= m_ppri) begin gone = m_xisr; m_xisr = 0; m_ppri = 255; end
          end
        end else if (reg_op == 2'd2) begin
          if (p < m_cppr && p <= m_ppri) begin gone = m_xisr; m_ppri = p; m_xisr = 2; end
          if (p > m_mfrr) begin e_rs = (m_need != 0); m_need = 0; end
          m_mfrr = p;
        end else begin
          lowr = int'(reg_wdata[31:24]);
          if (int'(reg_wdata[23:0]) != 2) begin e_eoi = 1; e_eoiid = int'(reg_wdata[23:0]); end
        end
        if (lowr >= 0) begin
          m_cppr = lowr;
          if (m_mfrr < lowr && m_mfrr <= m_ppri) begin gone = m_xisr; m_ppri = m_mfrr; m_xisr = 2; end
          e_rs = (m_need != 0); m_need = 0;
        end
      end else if (off_valid) begin
        p = int'(off_prio);
        if (p < m_cppr && p < m_mfrr && p < m_ppri) begin
          e_ok = 1; gone = m_xisr; m_xisr = int'(off_id); m_ppri = p;
        end else begin
          e_fail = 1; m_need = 1;
        end
      end
      e_rej = (gone != 0 && gone != 2);
      e_rejid = e_rej ? gone : 0;
      e_irq = (m_xisr != 0 && m_ppri < m_cppr);
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R6 rd_valid", {31'd0, rd_valid}, {31'd0, e_rd});
      chk("R6 rd_data", rd_data, e_rdd);
      chk("R2 dlv_ok", {31'd0, dlv_ok}, {31'd0, e_ok});
      chk("R4 dlv_fail", {31'd0, dlv_fail}, {31'd0, e_fail});
      chk("R3 rej_valid", {31'd0, rej_valid}, {31'd0, e_rej});
      chk("R3 rej_id", {8'd0, rej_id}, e_rejid);
      chk("R8 resend_req", {31'd0, resend_req}, {31'd0, e_rs});
      chk("R11 eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi});
      chk("R11 eoi_id", {8'd0, eoi_id}, e_eoiid);
      chk("R5 irq_out", {31'd0, irq_out}, {31'd0, e_irq});
    end
  end

  // drive at a negedge, return at the negedge after the processing edge
  task automatic regop(input logic [1:0] o, input logic [31:0] w);
    reg_valid = 1'b1; reg_op = o; reg_wdata = w;
    @(posedge clk); @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic offer(input logic [23:0] id, input logic [7:0] pr);
    off_valid = 1'b1; off_id = id; off_prio = pr;
    @(posedge clk); @(negedge clk);
    off_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    regop(2'd0, 32'd0);
    chk("R1 accept after reset", rd_data, 32'h0000_0000);
    regop(2'd1, 32'h0000_00FF);                 // lower priority to 0xFF
    offer(24'd5, 8'h10);
    chk("R2 offer taken", {31'd0, dlv_ok}, 32'd1);
    chk("R5 line raised", {31'd0, irq_out}, 32'd1);
    offer(24'd6, 8'h10);
    chk("R4 equal prio refused", {31'd0, dlv_fail}, 32'd1);
    offer(24'd7, 8'h08);
    chk("R3 displaced id", {rej_valid, 7'd0, rej_id}, {1'b1, 7'd0, 24'd5});
    regop(2'd1, 32'h0000_00FF);
    chk("R10 equal prio no report", {31'd0, resend_req}, 32'd0);
    regop(2'd2, 32'h0000_0030);
    regop(2'd2, 32'h0000_0040);
    chk("R8 raise reports flag", {31'd0, resend_req}, 32'd1);
    regop(2'd0, 32'd0);
    chk("R6 accept word", rd_data, 32'hFF00_0007);
    chk("R6 line dropped", {31'd0, irq_out}, 32'd0);
    regop(2'd1, 32'h0000_0004);
    regop(2'd2, 32'h0000_0002);
    chk("R7 IPI pending", {31'd0, irq_out}, 32'd1);
    regop(2'd0, 32'd0);
    chk("R7 accept IPI", rd_data, 32'h0400_0002);
    regop(2'd3, 32'h0A00_0002);
    chk("R11 IPI not forwarded", {31'd0, eoi_valid}, 32'd0);
    chk("R9 IPI repending", {31'd0, irq_out}, 32'd1);
    off_valid = 1'b1; off_id = 24'd9; off_prio = 8'h01;
    regop(2'd0, 32'd0);
    chk("R12 offer held off", {30'd0, dlv_ok, dlv_fail}, 32'd0);
    chk("R12 accept done", rd_data, 32'h0A00_0002);
    @(posedge clk); @(negedge clk);
    off_valid = 1'b0;
    chk("R12 retried offer", {31'd0, dlv_ok}, 32'd1);
    chk("R3 IPI not rejected", {31'd0, rej_valid}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      int k;
      k = int'($urandom % 9);
      reg_valid = ($urandom % 3 == 0);
      reg_op    = 2'($urandom % 4);
      reg_wdata = {(k == 8) ? 8'hFF : 8'(k), 16'd0, 8'($urandom % 5)};
      if (reg_op != 2'd3 && ($urandom % 2 == 0))
        reg_wdata[7:0] = (k == 8) ? 8'hFF : 8'(k);
      off_valid = ($urandom % 2 == 0);
      off_id    = 24'(1 + $urandom % 6);
      off_prio  = 8'($urandom % 8);
      @(negedge clk);
    end
    reg_valid = 1'b0; off_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule